// File: doc/BRIEF.md
# Cache snoop response agent

This block is the snoop side of a caching agent that sits on a shared memory bus. Whenever another requester starts a memory transaction, the agent captures the transaction's address and kind. It looks the address up in its own small direct-mapped tag and state array. It then answers on two active-low result lines during the snoop phase. While the lookup is still running, it holds the requester in the snoop phase by pulling both lines low. Once the lookup completes, it reports a miss, a clean hit or a hit on a modified line.

As a side effect of the snoop, the agent changes the line's coherence state. A read snoop makes a valid line shared. A read-and-invalidate snoop or a write snoop removes the line. When the agent owns the only up-to-date copy of the line, it puts the whole line on a data output in the cycle after the result.

The core fills and updates the array through a separate write port. Replacement, fills and the core's own cache datapath live elsewhere.

Top module: `snoop_agent`

## Requirements
- R1: After reset, `snp_hit_n` and `snp_hitm_n` are both 1, `line_valid` is 0, and every line is invalid.
- R2: A request is sampled on the clock edge where `bus_valid` is 1. Starting in the next cycle, both result lines are driven 0 for exactly LAT consecutive cycles (the stall code). Both lines are never 0 together at any other time.
- R3: The result cycle follows the last stall cycle. A snoop whose tag does not match, or whose line state is I, reports a miss (both lines 1) and leaves the line unchanged.
- R4: Bus kind 2'b00 is a read, and kind 2'b11 is handled as a read. A read that hits a clean line (S=2'b01 or E=2'b10) drives `snp_hit_n`=0 with `snp_hitm_n`=1, and the line becomes S.
- R5: A read that hits a modified line (M=2'b11) drives `snp_hitm_n`=0 with `snp_hit_n`=1. In the next cycle it drives `line_valid`=1 with the stored line on `line_data`. The line becomes S.
- R6: A read-and-invalidate snoop (kind 2'b10) that hits an S or E line reports a miss, never a clean hit, and the line becomes I (2'b00).
- R7: A read-and-invalidate snoop that hits an M line drives `snp_hitm_n`=0 and supplies the line in the next cycle. The line becomes I.
- R8: A write snoop (kind 2'b01) that hits an S or E line reports a miss and invalidates the line. A write snoop that hits an M line drives `snp_hitm_n`=0, supplies the line in the next cycle, and invalidates it.
- R9: The result is shown for one cycle only, followed by the optional data cycle, after which both lines return to 1. `line_valid` is 1 only in the cycle right after a modified-hit result. `line_data` is 0 whenever `line_valid` is 0.
- R10: Address bits [OFFS_W-1:0] are ignored. The next IDX_W bits select the set, and the upper bits form the tag. A core write updates the set from the next cycle on.
- R11: `bus_valid` is ignored while a snoop is in progress. A second request raised during the stall changes neither the running result nor the line states, and it starts no new snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus transaction is present this cycle |
| bus_addr | input | ADDR_W | Transaction address |
| bus_kind | input | 2 | 00 read, 01 write, 10 read-and-invalidate, 11 read |
| core_we | input | 1 | Core writes one set of the array |
| core_idx | input | IDX_W | Set written by the core |
| core_tag | input | TAG_W | Tag written by the core |
| core_state | input | 2 | Line state written by the core (00 I, 01 S, 10 E, 11 M) |
| core_line | input | LINE_W | Line data written by the core |
| snp_hit_n | output | 1 | Active-low clean-hit result |
| snp_hitm_n | output | 1 | Active-low modified-hit result |
| line_valid | output | 1 | Modified line is on `line_data` |
| line_data | output | LINE_W | Supplied line |

## Verification
The assertions check the handshake shape on every cycle:
- the stall code appears only while the lookup runs, and it lasts exactly LAT cycles;
- a read-and-invalidate or write snoop never produces a clean hit;
- line data appears exactly in the cycle after a modified-hit result and at no other time.

Only the bench scenarios can show that the result matches the stored state and that the state transitions actually took place. They do this by following each snoop with another snoop to the same set. The bench also shows that a request raised during a stall is dropped and that offset bits do not affect the lookup.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    BK_READ  = 2'b00,
    BK_WRITE = 2'b01,
    BK_RDINV = 2'b10,
    BK_RSVD  = 2'b11
  } bus_kind_e;

  typedef struct packed {
    logic     hit_n;
    logic     hitm_n;
    logic     supply;
    logic     upd;
    line_st_e nxt;
  } snp_rsp_t;

  // Response and next state from transaction kind, tag match and line state.
  function automatic snp_rsp_t snoop_decide(bus_kind_e kind, logic tag_eq, line_st_e st);
    snp_rsp_t r;
    r.hit_n  = 1'b1;
    r.hitm_n = 1'b1;
    r.supply = 1'b0;
    r.upd    = 1'b0;
    r.nxt    = st;
    if (tag_eq && st != ST_I) begin
      r.upd = 1'b1;
      if (kind == BK_RDINV || kind == BK_WRITE) begin
        r.nxt = ST_I;
        if (st == ST_M) begin
          r.hitm_n = 1'b0;
          r.supply = 1'b1;
        end
      end else begin
        r.nxt = ST_S;
        if (st == ST_M) begin
          r.hitm_n = 1'b0;
          r.supply = 1'b1;
        end else begin
          r.hit_n = 1'b0;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array import snoop_pkg::*; #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 9,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output line_st_e          rd_st,
  output logic [LINE_W-1:0] rd_line,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  logic [TAG_W-1:0]  cw_tag,
  input  line_st_e          cw_st,
  input  logic [LINE_W-1:0] cw_line,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_e          sw_st
);

  logic [TAG_W-1:0]  tag_mem  [SETS];
  line_st_e          st_mem   [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    wire snp_sel  = sw_en && (sw_idx == IDX_W'(s));
    wire core_sel = cw_en && (cw_idx == IDX_W'(s)) && !snp_sel;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_mem[s] <= ST_I;
      end else if (snp_sel) begin
        st_mem[s] <= sw_st;
      end else if (core_sel) begin
        st_mem[s] <= cw_st;
      end
    end

    always_ff @(posedge clk) begin
      if (core_sel) begin
        tag_mem[s]  <= cw_tag;
        line_mem[s] <= cw_line;
      end
    end
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_st   = st_mem[rd_idx];
  assign rd_line = line_mem[rd_idx];

endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl #(
  parameter int LAT = 3,
  localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic supply,
  output logic idle,
  output logic busy,
  output logic last,
  output logic res,
  output logic dat
);

  typedef enum logic [1:0] {C_IDLE, C_LOOK, C_RES, C_DATA} ctl_e;

  ctl_e             st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= C_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        C_IDLE: if (start) begin
          st  <= C_LOOK;
          cnt <= CNT_W'(LAT - 1);
        end
        C_LOOK: if (cnt == '0) st <= C_RES;
                else           cnt <= cnt - 1'b1;
        C_RES:  st <= supply ? C_DATA : C_IDLE;
        C_DATA: st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  assign idle = (st == C_IDLE);
  assign busy = (st == C_LOOK);
  assign last = busy && (cnt == '0);
  assign res  = (st == C_RES);
  assign dat  = (st == C_DATA);

endmodule

// File: rtl/snoop_agent.sv
module snoop_agent import snoop_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 4,
  parameter int SETS   = 8,
  parameter int LINE_W = 64,
  parameter int LAT    = 3,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic              core_we,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [TAG_W-1:0]  core_tag,
  input  logic [1:0]        core_state,
  input  logic [LINE_W-1:0] core_line,
  output logic              snp_hit_n,
  output logic              snp_hitm_n,
  output logic              line_valid,
  output logic [LINE_W-1:0] line_data
);

  localparam int LA_W = ADDR_W - OFFS_W;

  logic [LA_W-1:0]   la_q;
  bus_kind_e         kind_q;
  snp_rsp_t          rsp_q;
  logic [LINE_W-1:0] line_q;

  wire ctl_idle, lkp_busy, lkp_last, rsp_fire, dat_cyc;

  wire [IDX_W-1:0] look_idx = la_q[IDX_W-1:0];
  wire [TAG_W-1:0] look_tag = la_q[LA_W-1:IDX_W];

  logic [TAG_W-1:0]  rd_tag;
  line_st_e          rd_st;
  logic [LINE_W-1:0] rd_line;

  wire tag_eq = (rd_tag == look_tag);
  wire upd_en = rsp_fire && rsp_q.upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_q   <= '0;
      kind_q <= BK_READ;
    end else if (ctl_idle && bus_valid) begin
      la_q   <= bus_addr[ADDR_W-1:OFFS_W];
      kind_q <= bus_kind_e'(bus_kind);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q  <= '{hit_n: 1'b1, hitm_n: 1'b1, supply: 1'b0, upd: 1'b0, nxt: ST_I};
      line_q <= '0;
    end else if (lkp_last) begin
      rsp_q  <= snoop_decide(kind_q, tag_eq, rd_st);
      line_q <= rd_line;
    end
  end

  snp_ctrl #(.LAT(LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bus_valid),
    .supply (rsp_q.supply),
    .idle   (ctl_idle),
    .busy   (lkp_busy),
    .last   (lkp_last),
    .res    (rsp_fire),
    .dat    (dat_cyc)
  );

  snp_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (look_idx),
    .rd_tag  (rd_tag),
    .rd_st   (rd_st),
    .rd_line (rd_line),
    .cw_en   (core_we),
    .cw_idx  (core_idx),
    .cw_tag  (core_tag),
    .cw_st   (line_st_e'(core_state)),
    .cw_line (core_line),
    .sw_en   (upd_en),
    .sw_idx  (look_idx),
    .sw_st   (rsp_q.nxt)
  );

  assign snp_hit_n  = lkp_busy ? 1'b0 : (rsp_fire ? rsp_q.hit_n  : 1'b1);
  assign snp_hitm_n = lkp_busy ? 1'b0 : (rsp_fire ? rsp_q.hitm_n : 1'b1);
  assign line_valid = dat_cyc;
  assign line_data  = dat_cyc ? line_q : '0;

endmodule

// File: rtl/snoop_agent_chk.sv
module snoop_agent_chk #(
  parameter int LAT = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_hit_n,
  input logic       snp_hitm_n,
  input logic       line_valid,
  input logic       lkp_busy,
  input logic       rsp_fire,
  input logic [1:0] kind_q
);

  int unsigned stall_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                    stall_run <= 0;
    else if (lkp_busy)             stall_run <= stall_run + 1;
    else if (!rsp_fire)            stall_run <= 0;
  end

  // R2
  stall_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_busy |-> (!snp_hit_n && !snp_hitm_n));

  // R2
  no_stray_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_busy |-> (snp_hit_n || snp_hitm_n));

  // R2
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |-> (stall_run == LAT));

  // R6 R8
  no_clean_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && kind_q inside {2'b01, 2'b10}) |-> snp_hit_n);

  // R5 R7
  data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !snp_hitm_n) |=> line_valid);

  // R9
  data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(rsp_fire && !snp_hitm_n));

endmodule

bind snoop_agent snoop_agent_chk #(.LAT(LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .snp_hit_n  (snp_hit_n),
  .snp_hitm_n (snp_hitm_n),
  .line_valid (line_valid),
  .lkp_busy   (lkp_busy),
  .rsp_fire   (rsp_fire),
  .kind_q     (kind_q)
);

// File: tb/sim_snoop_agent.sv
`timescale 1ns/1ps
module sim_snoop_agent;

  localparam int ADDR_W = 16;
  localparam int OFFS_W = 4;
  localparam int SETS   = 8;
  localparam int LINE_W = 64;
  localparam int LAT    = 3;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]        bus_kind = 2'b00;
  logic              core_we = 1'b0;
  logic [IDX_W-1:0]  core_idx = '0;
  logic [TAG_W-1:0]  core_tag = '0;
  logic [1:0]        core_state = 2'b00;
  logic [LINE_W-1:0] core_line = '0;
  wire               snp_hit_n, snp_hitm_n, line_valid;
  wire  [LINE_W-1:0] line_data;

  always #2.5 clk = ~clk;

  snoop_agent #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SETS(SETS),
                .LINE_W(LINE_W), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_kind(bus_kind), .core_we(core_we), .core_idx(core_idx),
    .core_tag(core_tag), .core_state(core_state), .core_line(core_line),
    .snp_hit_n(snp_hit_n), .snp_hitm_n(snp_hitm_n),
    .line_valid(line_valid), .line_data(line_data)
  );

  // behavioural model of the array
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [1:0]        m_st   [SETS];
  logic [LINE_W-1:0] m_line [SETS];

  int vectors = 0;
  int errs    = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input logic hn, input logic hmn,
                     input logic dv, input logic [LINE_W-1:0] d);
    vectors++;
    if (snp_hit_n !== hn || snp_hitm_n !== hmn || line_valid !== dv || line_data !== d) begin
      errs++;
      $display("FAIL %s: hit_n=%b hitm_n=%b valid=%b data=%h, expected %b %b %b %h",
               req, snp_hit_n, snp_hitm_n, line_valid, line_data, hn, hmn, dv, d);
    end
  endtask

  task automatic install(input int idx, input logic [TAG_W-1:0] tg,
                         input logic [1:0] st, input logic [LINE_W-1:0] ln);
    @(negedge clk);
    core_we = 1'b1; core_idx = IDX_W'(idx); core_tag = tg;
    core_state = st; core_line = ln;
    @(negedge clk);
    core_we = 1'b0;
    m_tag[idx] = tg; m_st[idx] = st; m_line[idx] = ln;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] tg, input int idx,
                                            input int off);
    return {tg, IDX_W'(idx), OFFS_W'(off)};
  endfunction

  task automatic snoop(input string req, input logic [1:0] kind,
                       input logic [ADDR_W-1:0] a, input bit inject);
    int idx;
    logic [TAG_W-1:0] tg;
    logic eh, ehm;
    bit sup;
    idx = int'(a[OFFS_W +: IDX_W]);
    tg  = a[ADDR_W-1 -: TAG_W];
    eh = 1'b1; ehm = 1'b1; sup = 1'b0;
    if (m_st[idx] != 2'b00 && m_tag[idx] == tg) begin
      if (m_st[idx] == 2'b11) begin
        ehm = 1'b0; sup = 1'b1;
        m_st[idx] = (kind == 2'b01 || kind == 2'b10) ? 2'b00 : 2'b01;
      end else if (kind == 2'b01 || kind == 2'b10) begin
        m_st[idx] = 2'b00;
      end else begin
        eh = 1'b0; m_st[idx] = 2'b01;
      end
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_kind = kind;
    @(negedge clk);
    bus_valid = 1'b0;
    for (int c = 0; c < LAT; c++) begin
      chk({req, " stall R2"}, 1'b0, 1'b0, 1'b0, '0);
      if (c == 0 && inject) begin
        bus_valid = 1'b1; bus_kind = 2'b10; bus_addr = a;
      end
      @(negedge clk);
      bus_valid = 1'b0;
    end
    chk({req, " result"}, eh, ehm, 1'b0, '0);
    @(negedge clk);
    if (sup) begin
      chk({req, " data R9"}, 1'b1, 1'b1, 1'b1, m_line[idx]);
      @(negedge clk);
    end
    chk({req, " idle R9"}, 1'b1, 1'b1, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < SETS; i++) begin
      m_tag[i] = '0; m_st[i] = 2'b00; m_line[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset", 1'b1, 1'b1, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b1, 1'b1, 1'b0, '0);
    snoop("R1 empty array", 2'b00, mk(9'h000, 0, 0), 1'b0);

    install(0, 9'h011, 2'b11, 64'hA5A5_0000_1111_2222);
    install(1, 9'h022, 2'b10, 64'h0101_0202_0303_0404);
    install(2, 9'h033, 2'b01, 64'h0);
    install(3, 9'h044, 2'b11, 64'hDEAD_BEEF_CAFE_F00D);
    install(4, 9'h055, 2'b10, 64'h0);
    install(5, 9'h066, 2'b01, 64'h0);
    install(6, 9'h077, 2'b11, 64'h1234_5678_9ABC_DEF0);

    snoop("R3 invalid set", 2'b00, mk(9'h0AA, 7, 0), 1'b0);
    snoop("R3 tag mismatch", 2'b00, mk(9'h012, 0, 0), 1'b0);
    snoop("R5 read M", 2'b00, mk(9'h011, 0, 3), 1'b0);
    snoop("R4 R5 read after downgrade", 2'b00, mk(9'h011, 0, 0), 1'b0);
    snoop("R4 read E", 2'b00, mk(9'h022, 1, 0), 1'b0);
    snoop("R11 read S with stray request", 2'b00, mk(9'h022, 1, 0), 1'b1);
    snoop("R11 line kept", 2'b00, mk(9'h022, 1, 0), 1'b0);
    snoop("R6 rdinv S", 2'b10, mk(9'h033, 2, 0), 1'b0);
    snoop("R6 gone", 2'b00, mk(9'h033, 2, 0), 1'b0);
    snoop("R7 rdinv M", 2'b10, mk(9'h044, 3, 5), 1'b0);
    snoop("R7 gone", 2'b00, mk(9'h044, 3, 0), 1'b0);
    snoop("R8 write E", 2'b01, mk(9'h055, 4, 0), 1'b0);
    snoop("R8 gone", 2'b00, mk(9'h055, 4, 0), 1'b0);
    snoop("R8 write M", 2'b01, mk(9'h077, 6, 0), 1'b0);
    snoop("R8 M gone", 2'b00, mk(9'h077, 6, 0), 1'b0);
    snoop("R4 kind 11 on S", 2'b11, mk(9'h066, 5, 0), 1'b0);
    snoop("R10 offset ignored", 2'b00, mk(9'h066, 5, 15), 1'b0);
    install(7, 9'h0AA, 2'b10, 64'h0);
    snoop("R10 core write visible", 2'b00, mk(9'h0AA, 7, 9), 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule